// File: doc/BRIEF.md
# BCD Calendar Counter with Alarm

This block is a real-time counter that advances once per one-second tick pulse. Seconds, minutes and hours are kept as two-digit BCD values, and the day is a plain binary count. Software sets and reads all of them through an 8-bit register port. A control register starts and stops counting, reports when an update is in progress, and holds the alarm controls.

The alarm compares minute, hour and day. Each of the three fields has its own match enable. When the alarm fires it sets a sticky flag, which software clears by writing a 1 to it. An interrupt output is driven when both the flag and the interrupt enable are set.

Each tick opens a short busy window, and the counters change in the last cycle of that window. A time write that arrives during the window is held in a single slot. It is applied in the update cycle, after the increment, so the value software wrote is the one that remains.

Top module: `rtc_calendar`

## Requirements
- R1: Seconds and minutes count in BCD from 0x00 to 0x59. At 0x59 the next update gives 0x00, and the rollover carries one into the next field up.
- R2: Hours count in BCD from 0x00 to 0x23. A rollover from 0x23 to 0x00 adds one to the day count.
- R3: The day count is DAY_W bits wide, 15 by default. Bits 7:0 sit at address 0x18 and the upper bits at 0x19; unused upper bits read as 0. The count wraps from all ones to 0.
- R4: Register addresses are: control 0x14, seconds 0x15, minutes 0x16, hours 0x17, day low 0x18, day high 0x19, alarm minute 0x1A, alarm hour 0x1B, alarm day low 0x1C, alarm day high 0x1D. Any other address reads 0x00.
- R5: A tick advances the time only while control bit 0 (run) is 1.
- R6: Control bit 7 (busy) is read-only and ignores writes. It reads 1 for BUSY_CYCLES cycles, starting one cycle after a tick is accepted, and the counters change in the last of those cycles.
- R7: A write to seconds, minutes, hours or day made while busy is 1 is held and applied in the update cycle. After the update the field holds the written value. If several such writes arrive in one window, only the last is kept.
- R8: Control bit 2 (flag) sets in the update that brings the seconds to 0x00, provided at least one match enable is set and every enabled field matches the new time. The enables are bit 3 for minute, bit 4 for hour and bit 5 for day.
- R9: Writing control with bit 2 set clears the flag. Writing bit 2 as 0 leaves the flag unchanged.
- R10: alarm_irq is 1 exactly when the flag and control bit 1 (interrupt enable) are both 1.
- R11: After reset every register and alarm_irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| reg_addr | input | 8 | Register address for reads and writes |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| busy | output | 1 | Update window in progress |
| alarm_irq | output | 1 | Alarm interrupt |

## Verification
A wrong carry or wrap shows up in the minute, hour or day register on the first update after the lower field reaches its top value. So the checks preload each field one step short of its limit and read it back right after the update. A lost held write or an early increment shows up in the seconds value read right after the busy window closes. A flag that sets on a mismatched or disabled field shows up in control bit 2 and on alarm_irq within one cycle of that update.

// File: rtl/rtc_calendar.sv
module rtc_calendar #(
  parameter int BUSY_CYCLES = 4,
  parameter int DAY_W       = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1hz,
  input  logic [7:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       busy,
  output logic       alarm_irq
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam int HW = DAY_W - 8;
  localparam logic [7:0] A_CTRL = 8'h14, A_SEC = 8'h15, A_MIN = 8'h16, A_HR = 8'h17,
                         A_DLO = 8'h18, A_DHI = 8'h19, A_AMIN = 8'h1A, A_AHR = 8'h1B,
                         A_ADLO = 8'h1C, A_ADHI = 8'h1D;

  logic [7:0] sec_q, min_q, hr_q, amin_q, ahr_q;
  logic [DAY_W-1:0] day_q, aday_q;
  logic run_q, ien_q, alarm_flag, men_q, hen_q, den_q;
  logic [CW-1:0] cnt_q;
  logic pend_v;
  logic [7:0] pend_a, pend_d;

  function automatic logic [7:0] bcd_up(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  function automatic logic is_time(input logic [7:0] a);
    return (a >= A_SEC) && (a <= A_DHI);
  endfunction

  wire upd = (cnt_q == CW'(1));
  assign busy = (cnt_q != '0);

  wire s_wrap = (sec_q == 8'h59);
  wire m_wrap = (min_q == 8'h59);
  wire h_wrap = (hr_q == 8'h23);
  wire [7:0] s_nx = s_wrap ? 8'h00 : bcd_up(sec_q);
  wire [7:0] m_nx = s_wrap ? (m_wrap ? 8'h00 : bcd_up(min_q)) : min_q;
  wire [7:0] h_nx = (s_wrap && m_wrap) ? (h_wrap ? 8'h00 : bcd_up(hr_q)) : hr_q;
  wire [DAY_W-1:0] d_nx = (s_wrap && m_wrap && h_wrap) ? day_q + 1'b1 : day_q;

  wire any_en = men_q | hen_q | den_q;
  wire hit = s_wrap && any_en && (!men_q || m_nx == amin_q) &&
             (!hen_q || h_nx == ahr_q) && (!den_q || d_nx == aday_q);

  logic       tw_en;
  logic [7:0] tw_a, tw_d;
  always_comb begin
    tw_en = 1'b0;
    tw_a  = reg_addr;
    tw_d  = reg_wdata;
    if (reg_wr && is_time(reg_addr) && (!busy || upd)) begin
      tw_en = 1'b1;
    end else if (upd && pend_v) begin
      tw_en = 1'b1;
      tw_a  = pend_a;
      tw_d  = pend_d;
    end
  end

  wire ctrl_wr = reg_wr && (reg_addr == A_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0; min_q <= '0; hr_q <= '0; day_q <= '0;
      amin_q <= '0; ahr_q <= '0; aday_q <= '0;
      run_q <= 1'b0; ien_q <= 1'b0; alarm_flag <= 1'b0;
      men_q <= 1'b0; hen_q <= 1'b0; den_q <= 1'b0;
      cnt_q <= '0; pend_v <= 1'b0; pend_a <= '0; pend_d <= '0;
    end else begin
      if (busy) cnt_q <= cnt_q - 1'b1;
      else if (tick_1hz && run_q) cnt_q <= CW'(BUSY_CYCLES);

      if (upd) begin
        sec_q <= s_nx; min_q <= m_nx; hr_q <= h_nx; day_q <= d_nx;
        pend_v <= 1'b0;
      end
      if (tw_en) begin
        case (tw_a)
          A_SEC: sec_q <= tw_d;
          A_MIN: min_q <= tw_d;
          A_HR:  hr_q  <= tw_d;
          A_DLO: day_q[7:0] <= tw_d;
          A_DHI: day_q[DAY_W-1:8] <= tw_d[HW-1:0];
          default: ;
        endcase
      end
      if (reg_wr && busy && !upd && is_time(reg_addr)) begin
        pend_v <= 1'b1;
        pend_a <= reg_addr;
        pend_d <= reg_wdata;
      end

      if (reg_wr) begin
        case (reg_addr)
          A_AMIN: amin_q <= reg_wdata;
          A_AHR:  ahr_q  <= reg_wdata;
          A_ADLO: aday_q[7:0] <= reg_wdata;
          A_ADHI: aday_q[DAY_W-1:8] <= reg_wdata[HW-1:0];
          default: ;
        endcase
      end

      if (ctrl_wr) begin
        run_q <= reg_wdata[0];
        ien_q <= reg_wdata[1];
        men_q <= reg_wdata[3];
        hen_q <= reg_wdata[4];
        den_q <= reg_wdata[5];
        if (reg_wdata[2]) alarm_flag <= 1'b0;
      end
      if (upd && hit) alarm_flag <= 1'b1;
    end
  end

  wire [15:0] day16  = 16'(day_q);
  wire [15:0] aday16 = 16'(aday_q);

  always_comb begin
    case (reg_addr)
      A_CTRL: reg_rdata = {busy, 1'b0, den_q, hen_q, men_q, alarm_flag, ien_q, run_q};
      A_SEC:  reg_rdata = sec_q;
      A_MIN:  reg_rdata = min_q;
      A_HR:   reg_rdata = hr_q;
      A_DLO:  reg_rdata = day16[7:0];
      A_DHI:  reg_rdata = day16[15:8];
      A_AMIN: reg_rdata = amin_q;
      A_AHR:  reg_rdata = ahr_q;
      A_ADLO: reg_rdata = aday16[7:0];
      A_ADHI: reg_rdata = aday16[15:8];
      default: reg_rdata = 8'h00;
    endcase
  end

  assign alarm_irq = alarm_flag & ien_q;
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk #(
  parameter int BUSY_CYCLES = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_1hz,
  input logic       reg_wr,
  input logic [7:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       busy,
  input logic       alarm_irq,
  input logic       flag,
  input logic [7:0] sec
);
  logic [31:0] busy_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1;
    else busy_len <= '0;
  end

  assert_busy_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_len <= 32'(BUSY_CYCLES));

  assert_busy_from_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tick_1hz));

  assert_sec_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !reg_wr) |=> $stable(sec));

  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'h14 && reg_wdata[2] && !busy) |=> !flag);

  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_irq) |-> ($past(busy) || $past(reg_wr && reg_addr == 8'h14)));
endmodule

bind rtc_calendar rtc_calendar_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .busy(busy),
  .alarm_irq(alarm_irq), .flag(alarm_flag), .sec(sec_q)
);

// File: tb/test_rtc_calendar.sv
module test_rtc_calendar;
  localparam int BC = 4;
  logic clk = 1'b0, rst_n = 1'b0, tick_1hz = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic busy, alarm_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rtc_calendar #(.BUSY_CYCLES(BC), .DAY_W(15)) i_rtc_calendar (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .alarm_irq(alarm_irq));

  typedef struct { bit is_irq; logic [7:0] exp; string tag; } item_t;
  item_t q[$];

  task automatic exp_rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(posedge clk); #2;
    reg_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic exp_irq(input logic e, input string tag);
    item_t it;
    @(posedge clk); #2;
    it.is_irq = 1'b1; it.exp = {7'd0, e}; it.tag = tag;
    q.push_back(it);
  endtask

  always begin
    @(posedge clk); #4;
    if (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      act = it.is_irq ? {7'd0, alarm_irq} : reg_rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_wr = 1'b0;
  endtask

  task automatic pulse;
    @(posedge clk); #2;
    tick_1hz = 1'b1;
    @(posedge clk); #2;
    tick_1hz = 1'b0;
  endtask

  task automatic tick_wait;
    pulse();
    repeat (BC + 2) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    exp_rd(8'h15, 8'h00, "R11 seconds after reset");
    exp_rd(8'h14, 8'h00, "R11 control after reset");
    exp_rd(8'h19, 8'h00, "R11 day high after reset");
    exp_irq(1'b0, "R11 irq after reset");
    exp_rd(8'h30, 8'h00, "R4 unmapped address");

    wr(8'h15, 8'h58); wr(8'h16, 8'h59); wr(8'h17, 8'h23);
    wr(8'h18, 8'hFF); wr(8'h19, 8'h7F); wr(8'h14, 8'h01);
    tick_wait();
    exp_rd(8'h15, 8'h59, "R1 seconds step");
    exp_rd(8'h16, 8'h59, "R1 minutes hold without carry");
    tick_wait();
    exp_rd(8'h15, 8'h00, "R1 seconds wrap");
    exp_rd(8'h16, 8'h00, "R1 minutes wrap");
    exp_rd(8'h17, 8'h00, "R2 hours wrap");
    exp_rd(8'h18, 8'h00, "R3 day low wrap");
    exp_rd(8'h19, 8'h00, "R3 day high wrap");

    wr(8'h19, 8'hFF);
    exp_rd(8'h19, 8'h7F, "R3 day high unused bit");
    wr(8'h19, 8'h00);
    wr(8'h15, 8'h09);
    tick_wait();
    exp_rd(8'h15, 8'h10, "R1 BCD digit carry");
    wr(8'h15, 8'h00);

    wr(8'h14, 8'h00);
    tick_wait();
    exp_rd(8'h15, 8'h00, "R5 stopped counter holds");

    wr(8'h14, 8'h01);
    pulse();
    exp_rd(8'h14, 8'h81, "R6 busy during update");
    repeat (BC + 2) @(posedge clk);
    exp_rd(8'h14, 8'h01, "R6 busy clears");
    exp_rd(8'h15, 8'h01, "R6 update applied");
    wr(8'h14, 8'h81);
    exp_rd(8'h14, 8'h01, "R6 busy bit read-only");

    pulse();
    wr(8'h15, 8'h30);
    repeat (BC + 2) @(posedge clk);
    exp_rd(8'h15, 8'h30, "R7 held write wins over update");
    exp_rd(8'h16, 8'h00, "R7 other field unaffected");

    wr(8'h17, 8'h05); wr(8'h16, 8'h10); wr(8'h15, 8'h58);
    wr(8'h1A, 8'h11); wr(8'h1B, 8'h05);
    wr(8'h14, 8'h19);
    tick_wait();
    exp_rd(8'h14, 8'h19, "R8 no flag before seconds zero");
    tick_wait();
    exp_rd(8'h16, 8'h11, "R8 minute reached");
    exp_rd(8'h14, 8'h1D, "R8 flag on match");
    exp_irq(1'b0, "R10 irq masked");
    wr(8'h14, 8'h1B);
    exp_rd(8'h14, 8'h1F, "R9 writing zero keeps flag");
    exp_irq(1'b1, "R10 irq raised");
    wr(8'h14, 8'h1F);
    exp_rd(8'h14, 8'h1B, "R9 write one clears flag");
    exp_irq(1'b0, "R10 irq drops");

    wr(8'h14, 8'h3B); wr(8'h1C, 8'h05);
    wr(8'h16, 8'h10); wr(8'h15, 8'h59);
    tick_wait();
    exp_rd(8'h14, 8'h3B, "R8 day mismatch blocks flag");
    exp_irq(1'b0, "R10 no irq on mismatch");
    wr(8'h1C, 8'h00); wr(8'h16, 8'h10); wr(8'h15, 8'h59);
    tick_wait();
    exp_rd(8'h14, 8'h3F, "R8 flag with day match");
    exp_irq(1'b1, "R10 irq with day match");
    wr(8'h14, 8'h05);
    wr(8'h15, 8'h59);
    tick_wait();
    exp_rd(8'h14, 8'h01, "R8 no enables no flag");
    exp_rd(8'h1A, 8'h11, "R4 alarm minute readback");

    repeat (4) @(posedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      repeat (100000) @(posedge clk);
    join_any
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule